// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational execute stage for the integer register-register and register-immediate instructions of a 32-bit RISC core. It receives the raw 32-bit instruction word together with the two source operand values already read from the register file. In the same cycle it returns a result, the index of the register to write, a write-enable and a signed-overflow trap flag. The pipeline around it captures these values at its own stage boundary.

Arithmetic comes in trapping and non-trapping variants. The logic unit and the comparison unit take either a register operand or a 16-bit immediate. The immediate is sign- or zero-extended according to the instruction. A logarithmic shifter covers left, logical right and arithmetic right shifts, with the amount taken either from the instruction or from the first source operand. Upper-immediate loading is also supported. Multiply, divide, loads, stores and branches are handled elsewhere in the core.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0 with funct 0x20 (add) or 0x21 (addu), and opcodes 0x08 (addi) and 0x09 (addiu), produce the 32-bit wrapped sum of rs and the second operand. For addi and addiu the second operand is the sign-extended instruction bits [15:0].
- R2: Opcode 0 with funct 0x22 (sub) or 0x23 (subu) produces rs minus rt, wrapped to 32 bits.
- R3: add, sub and addi raise ovf_trap_o when the two's-complement result overflows. addu, subu and addiu never raise it. When a trap occurs, result_o still carries the wrapped value.
- R4: While ovf_trap_o is high, we_o is low.
- R5: Funct 0x24, 0x25, 0x26 and 0x27 give bitwise AND, OR, XOR and NOR of rs and rt. Opcodes 0x0C, 0x0D and 0x0E give AND, OR and XOR of rs with the zero-extended immediate.
- R6: Funct 0x2A (slt) and opcode 0x0A (slti) write 1 when rs is less than the second operand as signed numbers, and 0 otherwise. slti sign-extends its immediate.
- R7: Funct 0x2B (sltu) writes 1 or 0 from an unsigned comparison of rs and rt. Opcode 0x0B (sltiu) sign-extends its immediate and then compares unsigned.
- R8: Funct 0x00, 0x02 and 0x03 shift rt left, logically right and arithmetically right by instruction bits [10:6]. Logical shifts fill with zeros; the arithmetic shift fills with copies of rt bit 31.
- R9: Funct 0x04, 0x06 and 0x07 perform the same three shifts, using only rs bits [4:0] as the amount.
- R10: Opcode 0x0F places instruction bits [15:0] in result bits [31:16] and clears bits [15:0].
- R11: The destination is instruction bits [15:11] for opcode 0 and bits [20:16] for the immediate opcodes. A destination of 0 forces we_o low.
- R12: Any opcode or opcode-0 funct not listed above gives we_o low, ovf_trap_o low and result_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Computed result |
| we_o | output | 1 | Destination register write-enable |
| dest_o | output | 5 | Destination register index |
| ovf_trap_o | output | 1 | Signed overflow trap |

## Verification
Two suppression paths can act on the write-enable in the same evaluation: the overflow trap and the register-0 destination check. The bench provokes both at once by issuing an overflowing add, and an overflowing addi, whose destination field is 0. It then expects the trap to be raised and the write to be suppressed. It also runs each path alone to show that either one by itself keeps we_o low. The scoreboard model computes overflow from 64-bit signed arithmetic rather than from sign-bit rules, so the trap decision is judged independently of the design.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    valid;
    logic    use_imm;
    logic    imm_zext;
    logic    trap_en;
    logic    var_shamt;
    logic    dest_rt;
  } ctrl_t;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    if (opcode_i == OPC_REG) begin
      ctrl_o.valid = 1'b1;
      unique case (funct_i)
        FN_ADD:  begin ctrl_o.op = OP_ADD; ctrl_o.trap_en = 1'b1; end
        FN_ADDU: ctrl_o.op = OP_ADD;
        FN_SUB:  begin ctrl_o.op = OP_SUB; ctrl_o.trap_en = 1'b1; end
        FN_SUBU: ctrl_o.op = OP_SUB;
        FN_AND:  ctrl_o.op = OP_AND;
        FN_OR:   ctrl_o.op = OP_OR;
        FN_XOR:  ctrl_o.op = OP_XOR;
        FN_NOR:  ctrl_o.op = OP_NOR;
        FN_SLT:  ctrl_o.op = OP_SLT;
        FN_SLTU: ctrl_o.op = OP_SLTU;
        FN_SLL:  ctrl_o.op = OP_SLL;
        FN_SRL:  ctrl_o.op = OP_SRL;
        FN_SRA:  ctrl_o.op = OP_SRA;
        FN_SLLV: begin ctrl_o.op = OP_SLL; ctrl_o.var_shamt = 1'b1; end
        FN_SRLV: begin ctrl_o.op = OP_SRL; ctrl_o.var_shamt = 1'b1; end
        FN_SRAV: begin ctrl_o.op = OP_SRA; ctrl_o.var_shamt = 1'b1; end
        default: ctrl_o.valid = 1'b0;
      endcase
    end else begin
      ctrl_o.valid   = 1'b1;
      ctrl_o.use_imm = 1'b1;
      ctrl_o.dest_rt = 1'b1;
      unique case (opcode_i)
        OPC_ADDI:  begin ctrl_o.op = OP_ADD; ctrl_o.trap_en = 1'b1; end
        OPC_ADDIU: ctrl_o.op = OP_ADD;
        OPC_SLTI:  ctrl_o.op = OP_SLT;
        OPC_SLTIU: ctrl_o.op = OP_SLTU;
        OPC_ANDI:  begin ctrl_o.op = OP_AND; ctrl_o.imm_zext = 1'b1; end
        OPC_ORI:   begin ctrl_o.op = OP_OR;  ctrl_o.imm_zext = 1'b1; end
        OPC_XORI:  begin ctrl_o.op = OP_XOR; ctrl_o.imm_zext = 1'b1; end
        OPC_LUI:   ctrl_o.op = OP_LUI;
        default:   ctrl_o.valid = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/iexu_addsub.sv
module iexu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);

  localparam int M = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   full;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
  assign sum_o  = full[M:0];
  // signed overflow: operands agree in sign, result does not
  assign ovf_o  = (a_i[M] == b_eff[M]) && (sum_o[M] != a_i[M]);
  assign lt_s_o = sum_o[M] ^ ovf_o;
  assign lt_u_o = ~full[XLEN];

endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] data_o
);

  logic [XLEN-1:0] rev_in, rev_out;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  // left shifts reuse the right shifter on bit-reversed data
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = data_i[XLEN-1-i];
    assign rev_out[i] = stg[SHW][XLEN-1-i];
  end

  assign fill   = arith_i & ~left_i & data_i[XLEN-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
  end

  assign data_o = left_i ? rev_out : stg[SHW];

  always_comb begin
    if (amt_i == '0) AST_SHIFT_ZERO_PASS: assert (data_o == data_i); // R8
  end

endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
  import iexu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_NOR:  y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int REG_W = 5
) (
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic [XLEN-1:0]  result_o,
  output logic             we_o,
  output logic [REG_W-1:0] dest_o,
  output logic             ovf_trap_o
);

  localparam int SHW = $clog2(XLEN);
  localparam int M   = XLEN - 1;

  ctrl_t           ctrl;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0] imm_ext, opb, sum, logic_y, shift_y;
  logic [SHW-1:0]  shamt;
  logic            is_sub, ovf, lt_s, lt_u;

  iexu_decode u_decode (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .ctrl_o   (ctrl)
  );

  assign imm     = instr_i[IMM_W-1:0];
  assign imm_ext = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm}
                                 : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign opb     = ctrl.use_imm ? imm_ext : rt_val_i;
  assign is_sub  = ctrl.op inside {OP_SUB, OP_SLT, OP_SLTU};

  iexu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i    (rs_val_i),
    .b_i    (opb),
    .sub_i  (is_sub),
    .sum_o  (sum),
    .ovf_o  (ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  iexu_logic #(.XLEN(XLEN)) u_logic (
    .a_i  (rs_val_i),
    .b_i  (opb),
    .op_i (ctrl.op),
    .y_o  (logic_y)
  );

  assign shamt = ctrl.var_shamt ? rs_val_i[SHW-1:0] : instr_i[6 +: SHW];

  iexu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .data_i  (rt_val_i),
    .amt_i   (shamt),
    .left_i  (ctrl.op == OP_SLL),
    .arith_i (ctrl.op == OP_SRA),
    .data_o  (shift_y)
  );

  always_comb begin
    unique case (ctrl.op)
      OP_ADD, OP_SUB:                result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR: result_o = logic_y;
      OP_SLT:                        result_o = {{M{1'b0}}, lt_s};
      OP_SLTU:                       result_o = {{M{1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:        result_o = shift_y;
      OP_LUI:                        result_o = {imm, {(XLEN-IMM_W){1'b0}}};
      default:                       result_o = '0;
    endcase
  end

  assign dest_o     = ctrl.dest_rt ? instr_i[20:16] : instr_i[15:11];
  assign ovf_trap_o = ctrl.valid & ctrl.trap_en & ovf;
  assign we_o       = ctrl.valid & ~ovf_trap_o & (dest_o != '0);

  always_comb begin
    if (ovf_trap_o) AST_TRAP_BLOCKS_WE: assert (!we_o); // R4
    if (dest_o == '0) AST_ZERO_DEST_NO_WE: assert (!we_o); // R11
    if (!ctrl.valid) AST_ILLEGAL_QUIET: assert (!we_o && !ovf_trap_o && result_o == '0); // R12
    if ((instr_i[31:26] == OPC_ADDIU) ||
        (instr_i[31:26] == OPC_REG && instr_i[5:0] inside {FN_ADDU, FN_SUBU}))
      AST_UNSIGNED_NO_TRAP: assert (!ovf_trap_o); // R3
    if (ctrl.op == OP_SLT && rs_val_i[M] != opb[M])
      AST_SLT_SIGN_SPLIT: assert (result_o == {{M{1'b0}}, rs_val_i[M]}); // R6
    if (ctrl.op == OP_SLTU && rs_val_i[M] != opb[M])
      AST_SLTU_MSB_SPLIT: assert (result_o == {{M{1'b0}}, opb[M]}); // R7
  end

endmodule

// File: tb/int_exec_unit_tb_top.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;

  typedef struct {
    logic [31:0] instr;
    logic [31:0] res;
    logic        we;
    logic        trap;
    logic [4:0]  dest;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0, rs_v = '0, rt_v = '0;
  logic [31:0] result;
  logic        we, trap;
  logic [4:0]  dest;

  item_t sb[$];
  item_t cur;
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  int_exec_unit dut_i (
    .instr_i    (instr),
    .rs_val_i   (rs_v),
    .rt_val_i   (rt_v),
    .result_o   (result),
    .we_o       (we),
    .dest_o     (dest),
    .ovf_trap_o (trap)
  );

  function automatic logic [31:0] rins(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] iins(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic void model(input logic [31:0] ins, a, b,
                                output logic [31:0] r, output logic w, t, output logic [4:0] d);
    logic [5:0]  opc, fn;
    logic [31:0] se, ze;
    logic        ok;
    longint      s;
    opc = ins[31:26]; fn = ins[5:0];
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0000, ins[15:0]};
    ok = 1'b1; r = '0; t = 1'b0; s = 0;
    d = (opc == 6'h00) ? ins[15:11] : ins[20:16];
    if (opc == 6'h00) begin
      case (fn)
        6'h20: begin r = a + b; s = longint'($signed(a)) + longint'($signed(b)); t = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
        6'h21: r = a + b;
        6'h22: begin r = a - b; s = longint'($signed(a)) - longint'($signed(b)); t = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
        6'h23: r = a - b;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h26: r = a ^ b;
        6'h27: r = ~(a | b);
        6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2B: r = (a < b) ? 32'd1 : 32'd0;
        6'h00: r = b << ins[10:6];
        6'h02: r = b >> ins[10:6];
        6'h03: r = $signed(b) >>> ins[10:6];
        6'h04: r = b << a[4:0];
        6'h06: r = b >> a[4:0];
        6'h07: r = $signed(b) >>> a[4:0];
        default: ok = 1'b0;
      endcase
    end else begin
      case (opc)
        6'h08: begin r = a + se; s = longint'($signed(a)) + longint'($signed(se)); t = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
        6'h09: r = a + se;
        6'h0A: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
        6'h0B: r = (a < se) ? 32'd1 : 32'd0;
        6'h0C: r = a & ze;
        6'h0D: r = a | ze;
        6'h0E: r = a ^ ze;
        6'h0F: r = {ins[15:0], 16'h0000};
        default: ok = 1'b0;
      endcase
    end
    if (!ok) r = '0;
    w = ok && !t && (d != 5'd0);
  endfunction

  task automatic send(input logic [31:0] ins, a, b, input string tag);
    item_t it;
    it.instr = ins; it.tag = tag;
    model(ins, a, b, it.res, it.we, it.trap, it.dest);
    @(posedge clk);
    instr = ins; rs_v = a; rt_v = b;
    sb.push_back(it);
  endtask

  // monitor: results sampled mid-cycle, compared against the queue
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      n_run++;
      if (result !== cur.res || we !== cur.we || trap !== cur.trap || dest !== cur.dest) begin
        n_fail++;
        $display("FAIL %s instr=%h: got result=%h we=%b dest=%0d trap=%b, expected result=%h we=%b dest=%0d trap=%b",
                 cur.tag, cur.instr, result, we, dest, trap, cur.res, cur.we, cur.dest, cur.trap);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle word: shift into register 0
    send(32'h0, 32'h0, 32'h0, "R11");
    // R1 sums
    send(rins(5'd9, 5'd10, 5'd8, 5'd0, 6'h20), 32'd100, 32'd23, "R1");
    send(rins(5'd9, 5'd10, 5'd8, 5'd0, 6'h21), 32'hFFFF_FFFF, 32'd2, "R1");
    send(iins(6'h08, 5'd9, 5'd8, 16'hFFFB), 32'd10, 32'd0, "R1");
    send(iins(6'h09, 5'd9, 5'd8, 16'h8000), 32'd0, 32'd0, "R1");
    // R2 differences
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h22), 32'd5, 32'd9, "R2");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h23), 32'd0, 32'd1, "R2");
    // R3 overflow
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'd1, "R3");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h7FFF_FFFF, 32'd1, "R3");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h8000_0000, 32'hFFFF_FFFF, "R3");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h22), 32'h8000_0000, 32'd1, "R3");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h23), 32'h8000_0000, 32'd1, "R3");
    send(iins(6'h08, 5'd1, 5'd4, 16'h0001), 32'h7FFF_FFFF, 32'd0, "R3");
    send(iins(6'h09, 5'd1, 5'd4, 16'h0001), 32'h7FFF_FFFF, 32'd0, "R3");
    // R4 trap and register-0 destination together
    send(rins(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4");
    send(iins(6'h08, 5'd1, 5'd0, 16'h8000), 32'h8000_0000, 32'd0, "R4");
    // R5 logic
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h24), 32'hF0F0_1234, 32'hFF00_FF00, "R5");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h25), 32'hF0F0_1234, 32'h0F00_00FF, "R5");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h26), 32'hAAAA_5555, 32'hFFFF_0000, "R5");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h27), 32'hAAAA_0000, 32'h0000_5555, "R5");
    send(iins(6'h0C, 5'd1, 5'd7, 16'hFFFF), 32'hDEAD_BEEF, 32'd0, "R5");
    send(iins(6'h0D, 5'd1, 5'd7, 16'h8001), 32'h1200_0000, 32'd0, "R5");
    send(iins(6'h0E, 5'd1, 5'd7, 16'hF0F0), 32'hFFFF_FFFF, 32'd0, "R5");
    // R6 signed compare
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h2A), 32'hFFFF_FFFF, 32'd1, "R6");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h2A), 32'd7, 32'd7, "R6");
    send(iins(6'h0A, 5'd1, 5'd3, 16'hFFFE), 32'hFFFF_FFFD, 32'd0, "R6");
    // R7 unsigned compare
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h2B), 32'hFFFF_FFFF, 32'd1, "R7");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h2B), 32'd1, 32'hFFFF_FFFF, "R7");
    send(iins(6'h0B, 5'd1, 5'd3, 16'hFFFF), 32'd5, 32'd0, "R7");
    send(iins(6'h0B, 5'd1, 5'd3, 16'hFFFF), 32'hFFFF_FFFF, 32'd0, "R7");
    // R8 constant shifts
    send(rins(5'd0, 5'd12, 5'd13, 5'd2, 6'h00), 32'hFFFF_FFFF, 32'h4000_0003, "R8");
    send(rins(5'd0, 5'd12, 5'd13, 5'd31, 6'h00), 32'd0, 32'h0000_0001, "R8");
    send(rins(5'd0, 5'd12, 5'd13, 5'd4, 6'h02), 32'd0, 32'h8000_00F0, "R8");
    send(rins(5'd0, 5'd12, 5'd13, 5'd4, 6'h03), 32'd0, 32'h8000_00F0, "R8");
    send(rins(5'd0, 5'd12, 5'd13, 5'd0, 6'h03), 32'd0, 32'h9234_5678, "R8");
    send(rins(5'd0, 5'd12, 5'd13, 5'd31, 6'h03), 32'd0, 32'h8000_0000, "R8");
    // R9 register-amount shifts, upper rs bits ignored
    send(rins(5'd1, 5'd12, 5'd13, 5'd7, 6'h04), 32'hFFFF_FFE3, 32'h0000_0011, "R9");
    send(rins(5'd1, 5'd12, 5'd13, 5'd0, 6'h06), 32'h0000_0028, 32'hF000_0000, "R9");
    send(rins(5'd1, 5'd12, 5'd13, 5'd0, 6'h07), 32'h0000_0028, 32'hF000_0000, "R9");
    send(rins(5'd1, 5'd12, 5'd13, 5'd0, 6'h07), 32'h0000_0020, 32'h8765_4321, "R9");
    // R10 upper immediate
    send(iins(6'h0F, 5'd3, 5'd8, 16'h5555), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    // R11 destination selection and register 0
    send(iins(6'h09, 5'd1, 5'd0, 16'h0004), 32'd1, 32'd0, "R11");
    send(rins(5'd1, 5'd2, 5'd0, 5'd0, 6'h25), 32'd1, 32'd2, "R11");
    send(iins(6'h0D, 5'd1, 5'd31, 16'h0001), 32'd0, 32'd0, "R11");
    // R12 unrecognised encodings
    send(iins(6'h3F, 5'd1, 5'd5, 16'h1234), 32'h7FFF_FFFF, 32'd1, "R12");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h01), 32'h1234, 32'h5678, "R12");
    send(rins(5'd1, 5'd2, 5'd3, 5'd0, 6'h18), 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R12");
    wait (sb.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R12 watchdog: pending=%0d expected 0", sb.size());
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule